// File: doc/BRIEF.md
# Corner-Indexed Delay-Line Configuration Table

This block stores the tap settings for an emulated critical path made of two delay lines in series: one made of logic stages and one made of buffered wire segments. The settings form a grid of sub-tables. A measured logic-speed bin picks the row and a measured wire-speed bin picks the column. Each sub-table then holds one entry per performance target. Because every entry carries its own logic count and its own wire count, the emulated path keeps the same blend of gate delay and wire delay as the real critical path at that corner.

The contents are written after silicon measurement through a serial shift chain. The table can be rewritten at any time. During normal operation the block watches the two bin indices and the target index. It places the selected pair of tap codes on registered outputs, together with a flag that marks the codes as settled.

Top module: `dline_corner_table`

## Requirements
- R1: While reset is held, and after it is released before the first clock edge, `logic_code` and `wire_code` are 0 and `codes_valid` is 0. All table entries reset to 0.
- R2: The table holds 5 x 5 x 4 entries of 10 bits, which is 1000 bits in all. Entry number e = (lbin*5 + wbin)*4 + tgt. Bits [9:5] of an entry are the logic tap count and bits [4:0] are the wire tap count. Each clock edge with `shift_en` high moves the chain by one bit. The first of 1000 bits sent lands in bit 9 of entry 99, and the last lands in bit 0 of entry 0.
- R3: The row is chosen by `lbin`, the column by `wbin` and the entry inside the sub-table by `tgt`, with all three given as binary numbers. On the first clock edge after a new selection, the outputs take bits [9:5] and [4:0] of that entry.
- R4: On the edge that loads a changed selection, `codes_valid` is 0. It becomes 1 on the next edge, provided the selection is held and stays legal.
- R5: While `shift_en` is high, both codes hold their values and `codes_valid` goes to 0. After `shift_en` falls, the first edge loads the codes from the new contents, and `codes_valid` rises on the second edge.
- R6: A bin index of 5 or more is illegal. While it is applied, the codes hold their last values and `codes_valid` is 0.
- R7: The behavioural series delay (logic_code * unit logic delay + wire_code * unit wire delay) that the selected codes give equals the delay that the stored entry calls for.
- R8: Loading a second set of contents replaces the first set completely. The selections that follow return the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Shift the configuration chain by one bit per edge |
| shift_in | input | 1 | Serial configuration data |
| lbin | input | 3 | Logic-speed bin index (row) |
| wbin | input | 3 | Wire-speed bin index (column) |
| tgt | input | 2 | Performance target index |
| logic_code | output | 5 | Number of logic stages for the logic delay line |
| wire_code | output | 5 | Number of wire segments for the wire delay line |
| codes_valid | output | 1 | The codes are settled for the current selection |

## Verification
A wrong bit position or a wrong entry number in the chain appears at the ports the first time the affected entry is selected. It then shows one clock edge later as a wrong logic or wire code, and so as a wrong series delay. A wrong hold or settle flag appears within one or two edges of a selection change, a change of `shift_en` or an illegal index. The codes move while they should be frozen, or `codes_valid` is high in the cycle it must be low. A chain that is cut or misordered is exposed by the second load, because all of its entries differ from those of the first load.

// File: rtl/dct_pkg.sv
package dct_pkg;

  // Linear position of an entry inside the chain.
  function automatic int unsigned entry_pos(input int unsigned lb, input int unsigned wb,
                                            input int unsigned tg, input int unsigned n_wb,
                                            input int unsigned n_tg);
    return (lb * n_wb + wb) * n_tg + tg;
  endfunction

  // Series delay of the emulated path for a given pair of tap counts.
  function automatic int unsigned series_delay(input int unsigned l_taps, input int unsigned w_taps,
                                               input int unsigned unit_l, input int unsigned unit_w);
    return l_taps * unit_l + w_taps * unit_w;
  endfunction

endpackage

// File: rtl/dct_bin_decode.sv
module dct_bin_decode #(
  parameter int NB     = 5,
  parameter bit ONEHOT = 1'b0,
  parameter int BW     = (NB > 1) ? $clog2(NB) : 1,
  parameter int IW     = ONEHOT ? NB : BW
) (
  input  logic [IW-1:0] bin_in,
  output logic [BW-1:0] idx,
  output logic          ok
);

  generate
    if (ONEHOT) begin : g_onehot
      always_comb begin
        idx = '0;
        for (int i = 0; i < NB; i++) begin
          if (bin_in[i]) idx = BW'(i);
        end
        ok = $onehot(bin_in);
      end
    end else begin : g_binary
      always_comb begin
        idx = BW'(bin_in);
        ok  = (int'(bin_in) < NB);
      end
    end
  endgenerate

  // R6: a legal index never points outside the bin range
  always_comb begin
    if (ok) p_idx_range_r6 : assert (int'(idx) < NB);
  end

endmodule

// File: rtl/dct_chain.sv
module dct_chain #(
  parameter int ENTRIES = 100,
  parameter int EW      = 10,
  parameter int AW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          shift_in,
  input  logic [AW-1:0] rd_idx,
  output logic [EW-1:0] rd_word
);

  localparam int TOTAL = ENTRIES * EW;

  logic [TOTAL-1:0] chain;
  logic [EW-1:0]    ent [ENTRIES];
  logic             shift_step;

  assign shift_step = shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          chain <= '0;
    else if (shift_step) chain <= {chain[TOTAL-2:0], shift_in};
  end

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      assign ent[e] = chain[e*EW +: EW];
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    if (int'(rd_idx) < ENTRIES) rd_word = ent[rd_idx];
  end

  // R2: each shift step takes the serial bit into the chain head
  p_chain_head_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    shift_step |=> chain[0] == $past(shift_in));

  // R8: contents change only by shifting
  p_chain_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    !shift_step |=> $stable(chain));

endmodule

// File: rtl/dline_corner_table.sv
module dline_corner_table #(
  parameter int LBINS  = 5,
  parameter int WBINS  = 5,
  parameter int NTGT   = 4,
  parameter int CW     = 5,
  parameter bit ONEHOT = 1'b0,
  parameter int LBW    = (LBINS > 1) ? $clog2(LBINS) : 1,
  parameter int WBW    = (WBINS > 1) ? $clog2(WBINS) : 1,
  parameter int LIW    = ONEHOT ? LBINS : LBW,
  parameter int WIW    = ONEHOT ? WBINS : WBW,
  parameter int TW     = (NTGT > 1) ? $clog2(NTGT) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           shift_in,
  input  logic [LIW-1:0] lbin,
  input  logic [WIW-1:0] wbin,
  input  logic [TW-1:0]  tgt,
  output logic [CW-1:0]  logic_code,
  output logic [CW-1:0]  wire_code,
  output logic           codes_valid
);

  import dct_pkg::*;

  localparam int ENTRIES = LBINS * WBINS * NTGT;
  localparam int EW      = 2 * CW;
  localparam int AW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int KW      = 1 + LBW + WBW + TW;

  logic [LBW-1:0] lidx;
  logic [WBW-1:0] widx;
  logic           l_ok, w_ok, t_ok, sel_ok;
  logic [AW-1:0]  rd_idx;
  logic [EW-1:0]  rd_word;
  logic [KW-1:0]  sel_key, sel_prev;
  logic           shift_q;
  logic           load_now, sel_steady;

  dct_bin_decode #(.NB(LBINS), .ONEHOT(ONEHOT), .BW(LBW), .IW(LIW)) u_ldec (
    .bin_in(lbin), .idx(lidx), .ok(l_ok));

  dct_bin_decode #(.NB(WBINS), .ONEHOT(ONEHOT), .BW(WBW), .IW(WIW)) u_wdec (
    .bin_in(wbin), .idx(widx), .ok(w_ok));

  assign t_ok    = (int'(tgt) < NTGT);
  assign sel_ok  = l_ok && w_ok && t_ok;
  assign rd_idx  = AW'(entry_pos(int'(lidx), int'(widx), int'(tgt), WBINS, NTGT));
  assign sel_key = {sel_ok, lidx, widx, tgt};

  dct_chain #(.ENTRIES(ENTRIES), .EW(EW), .AW(AW)) u_chain (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .shift_in(shift_in),
    .rd_idx(rd_idx), .rd_word(rd_word));

  // Named events for the checks below
  assign load_now   = !shift_en && sel_ok;
  assign sel_steady = load_now && !shift_q && (sel_key == sel_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      logic_code  <= '0;
      wire_code   <= '0;
      codes_valid <= 1'b0;
      sel_prev    <= '0;
      shift_q     <= 1'b1;
    end else begin
      sel_prev    <= sel_key;
      shift_q     <= shift_en;
      codes_valid <= sel_steady;
      if (load_now) begin
        logic_code <= rd_word[EW-1:CW];
        wire_code  <= rd_word[CW-1:0];
      end
    end
  end

  // R5: shifting freezes the codes
  p_freeze_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> $stable(logic_code) && $stable(wire_code));

  // R5: no valid flag while the table is being rewritten
  p_shift_invalid_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> !codes_valid);

  // R6: an illegal selection holds the codes and clears the flag
  p_bad_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ok |=> $stable(logic_code) && $stable(wire_code) && !codes_valid);

  // R4: a valid flag means the codes did not move on that edge
  p_valid_steady_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    codes_valid |-> $stable(logic_code) && $stable(wire_code));

  // R4: the flag only rises after the codes have settled for one edge
  p_valid_rise_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(codes_valid) |-> $past(load_now));

endmodule

// File: tb/dline_corner_table_test.sv
module dline_corner_table_test;

  localparam int NL = 5, NW = 5, NT = 4, CW = 5;
  localparam int ENT = NL * NW * NT;
  localparam int EW = 2 * CW;
  localparam int TOTAL = ENT * EW;
  localparam int UNIT_L = 7, UNIT_W = 13;
  localparam int NVEC = 8;
  // {lbin[7:5], wbin[4:2], tgt[1:0]}
  localparam logic [7:0] VEC [NVEC] = '{
    {3'd0, 3'd0, 2'd0}, {3'd4, 3'd4, 2'd3}, {3'd2, 3'd3, 2'd1}, {3'd1, 3'd4, 2'd2},
    {3'd4, 3'd0, 2'd0}, {3'd3, 3'd2, 2'd3}, {3'd0, 3'd4, 2'd1}, {3'd2, 3'd2, 2'd2}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b0, shift_in = 1'b0;
  logic [2:0] lbin = '0, wbin = '0;
  logic [1:0] tgt = '0;
  logic [CW-1:0] logic_code, wire_code;
  logic codes_valid;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dline_corner_table uut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .shift_in(shift_in),
    .lbin(lbin), .wbin(wbin), .tgt(tgt),
    .logic_code(logic_code), .wire_code(wire_code), .codes_valid(codes_valid));

  function automatic logic [EW-1:0] model_word(input int seed, input int e);
    logic [CW-1:0] l, w;
    l = CW'((e * 7 + seed) % 32);
    w = CW'((e * 11 + 2 * seed + 1) % 32);
    return {l, w};
  endfunction

  function automatic int model_entry(input int lb, input int wb, input int tg);
    return lb * NW * NT + wb * NT + tg;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_table(input int seed);
    for (int b = TOTAL - 1; b >= 0; b--) begin
      logic [EW-1:0] w;
      w = model_word(seed, b / EW);
      @(negedge clk);
      shift_en = 1'b1;
      shift_in = w[b % EW];
    end
    @(negedge clk);
    shift_en = 1'b0;
    shift_in = 1'b0;
  endtask

  task automatic select_and_check(input int seed, input int lb, input int wb, input int tg,
                                  input string tag);
    logic [EW-1:0] w;
    w = model_word(seed, model_entry(lb, wb, tg));
    lbin = 3'(lb); wbin = 3'(wb); tgt = 2'(tg);
    @(posedge clk); @(negedge clk);
    chk({tag, " R3 logic code"}, int'(logic_code), int'(w[EW-1:CW]));
    chk({tag, " R3 wire code"}, int'(wire_code), int'(w[CW-1:0]));
    chk({tag, " R4 valid low on change"}, int'(codes_valid), 0);
    @(posedge clk); @(negedge clk);
    chk({tag, " R4 valid one edge later"}, int'(codes_valid), 1);
    chk({tag, " R7 series delay"},
        int'(logic_code) * UNIT_L + int'(wire_code) * UNIT_W,
        int'(w[EW-1:CW]) * UNIT_L + int'(w[CW-1:0]) * UNIT_W);
  endtask

  initial begin
    #(100000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12;
    // R1: reset state
    chk("R1 logic code in reset", int'(logic_code), 0);
    chk("R1 wire code in reset", int'(wire_code), 0);
    chk("R1 valid in reset", int'(codes_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 logic code after release", int'(logic_code), 0);
    chk("R1 valid after release", int'(codes_valid), 0);
    @(posedge clk); @(negedge clk);
    chk("R1 empty table gives zero", int'(logic_code), 0);

    // R2: serial load of the first contents
    load_table(3);
    // R5: after shift_en falls, codes load on the first edge, valid on the second
    begin
      logic [EW-1:0] w0;
      w0 = model_word(3, 0);
      chk("R5 codes frozen at end of shift", int'(logic_code), 0);
      @(posedge clk); @(negedge clk);
      chk("R5 R2 first entry logic", int'(logic_code), int'(w0[EW-1:CW]));
      chk("R5 R2 first entry wire", int'(wire_code), int'(w0[CW-1:0]));
      chk("R5 valid low on first edge", int'(codes_valid), 0);
      @(posedge clk); @(negedge clk);
      chk("R5 valid on second edge", int'(codes_valid), 1);
    end

    // Vector walk over rows, columns and targets (R2, R3, R4, R7)
    for (int v = 1; v < NVEC; v++) begin
      select_and_check(3, int'(VEC[v][7:5]), int'(VEC[v][4:2]), int'(VEC[v][1:0]), "vec");
    end
    // R2: the last entry carries the first bit sent
    select_and_check(3, 4, 4, 3, "R2 last entry");
    select_and_check(3, 0, 0, 0, "R2 first entry");

    // R6: illegal bin indices
    begin
      logic [CW-1:0] hl, hw;
      hl = logic_code; hw = wire_code;
      lbin = 3'd5;
      @(posedge clk); @(negedge clk);
      chk("R6 logic code held on bad row", int'(logic_code), int'(hl));
      chk("R6 valid low on bad row", int'(codes_valid), 0);
      lbin = 3'd1; wbin = 3'd7;
      @(posedge clk); @(negedge clk);
      chk("R6 wire code held on bad column", int'(wire_code), int'(hw));
      chk("R6 valid low on bad column", int'(codes_valid), 0);
    end
    select_and_check(3, 1, 2, 3, "R6 recovery");

    // R5: freeze during a partial rewrite, checked mid-chain
    begin
      logic [CW-1:0] hl, hw;
      hl = logic_code; hw = wire_code;
      @(negedge clk);
      shift_en = 1'b1; shift_in = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R5 logic code frozen mid shift", int'(logic_code), int'(hl));
      chk("R5 wire code frozen mid shift", int'(wire_code), int'(hw));
      chk("R5 valid low mid shift", int'(codes_valid), 0);
      shift_en = 1'b0;
    end

    // R8: full rewrite with new contents
    load_table(9);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    for (int v = 0; v < NVEC; v++) begin
      select_and_check(9, int'(VEC[v][7:5]), int'(VEC[v][4:2]), int'(VEC[v][1:0]), "R8 reload");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule